// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block decides which analog sections of a successive-approximation converter receive power. It watches four things: the two power-select bits of the most recent command word, a one-cycle pulse when a start bit is detected, a one-cycle pulse when a conversion completes, and an active-low hardware shutdown pin. From these it drives three enables: the comparator, the bandgap and reference buffer, and the rest of the analog circuitry. It also raises a reference-ready flag once a settling timer has run out.

Each command chooses the power state that follows its own conversion, and that state is entered as soon as the conversion completes. A nap state keeps the internal reference alive. A sleep state switches everything off. A third choice keeps all sections powered. A new start bit wakes the block from either low-power state. Each way of waking reloads the settling timer with its own length, counted in system clock cycles. When an external reference is in use, the reference buffer stays off, no settling wait applies, and nap behaves exactly like sleep. Pulling the shutdown pin low forces sleep, aborts any conversion in flight and drops that conversion's power request.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the block shows `ana_en`=1, `ref_en`=!`ext_ref`, `cmp_en`=0 and `conv_abort`=0. `ref_ready` first rises SLEEP_WAKE_CYC clock edges after the last reset edge, or immediately when `ext_ref`=1.
- R2: `pd_sel`=2'b00 at the edge where `conv_done` ends a conversion selects sleep. On the next cycle `ana_en`, `ref_en`, `cmp_en` and `ref_ready` are all 0.
- R3: `pd_sel`=2'b01 at completion selects nap. `ana_en`, `cmp_en` and `ref_ready` go to 0, while `ref_en` stays 1 when `ext_ref`=0.
- R4: `pd_sel`=2'b10 or 2'b11 at completion keeps `ana_en`, `ref_en` and `ref_ready` at 1. Only `cmp_en` drops.
- R5: A `start_det` pulse while `shdn_n`=1 sets `ana_en`=1 and `cmp_en`=1 on the next cycle, from any power state.
- R6: After a wake edge, `ref_ready` stays 0 for exactly NAP_WAKE_CYC cycles (wake from nap) or SLEEP_WAKE_CYC cycles (wake from sleep or shutdown), then rises. A start that arrives while the block is already powered leaves `ref_ready` at 1.
- R7: With `ext_ref`=1, `ref_en` is 0 in every state, and `ref_ready` is 1 on the first cycle after any wake, whether the block was in nap or in sleep.
- R8: `shdn_n`=0 forces `ana_en`, `ref_en`, `cmp_en` and `ref_ready` to 0 on the next cycle and for as long as it stays low. `start_det` pulses during that time have no effect.
- R9: When `shdn_n` returns to 1, the block powers up (`ana_en`=1, `ref_en`=!`ext_ref`), and the sleep settling count applies to `ref_ready`.
- R10: `shdn_n` falling while a conversion is open gives a single-cycle `conv_abort` pulse. A later `conv_done` for that conversion is ignored, so the block stays powered.
- R11: `cmp_en` rises with each `start_det` and falls on the cycle after the matching `conv_done`, in every power-select setting, including 2'b1x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Hardware shutdown, active low, already synchronised |
| ext_ref | input | 1 | 1 = external reference in use |
| pd_sel | input | 2 | Power-select bits of the latest command |
| start_det | input | 1 | One-cycle pulse: start bit seen while selected |
| conv_done | input | 1 | One-cycle pulse: conversion completed |
| cmp_en | output | 1 | Comparator enable |
| ref_en | output | 1 | Bandgap and reference buffer enable |
| ana_en | output | 1 | Enable for the remaining analog circuitry |
| ref_ready | output | 1 | Reference has settled |
| conv_abort | output | 1 | One-cycle pulse: open conversion killed by shutdown |

## Verification
The properties assume that `start_det` and `conv_done` are single-cycle pulses that never arrive in the same cycle. They also assume that `pd_sel` is stable at the edge where `conv_done` is seen, and that `ext_ref` changes only while no settling count is running. The stimulus respects all of these: each pulse is driven for exactly one cycle by a task, `pd_sel` is set together with the start and held until completion, and `ext_ref` is toggled only when the block is idle and powered. The random phase draws the power-select value and the conversion length, and keeps those rules.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_NAP    = 2'd1,
        PS_SLEEP  = 2'd2
    } pwr_state_t;

    // Power-select decode: 00 -> sleep, 01 -> nap, 1x -> stay powered
    function automatic pwr_state_t pd_decode(input logic [1:0] pd);
        case (pd)
            2'b00:   return PS_SLEEP;
            2'b01:   return PS_NAP;
            default: return PS_ACTIVE;
        endcase
    endfunction

    // Settling length applied when leaving a given state
    function automatic int unsigned wake_cycles(input pwr_state_t from,
                                                input logic ext,
                                                input int unsigned nap_len,
                                                input int unsigned sleep_len);
        if (ext)
            return 0;
        case (from)
            PS_NAP:   return nap_len;
            PS_SLEEP: return sleep_len;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shdn_n,
    input  logic       start_det,
    input  logic       conv_done,
    input  logic [1:0] pd_sel,
    output pwr_state_t state_o,
    output logic       busy_o,
    output logic       abort_o,
    output logic       wake_o,
    output pwr_state_t wake_from_o
);

    logic shdn_q;

    // Wake: start bit or shutdown release while not fully powered
    always_comb begin
        wake_from_o = state_o;
        wake_o      = shdn_n && (state_o != PS_ACTIVE) && (start_det || !shdn_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= PS_ACTIVE;
            busy_o  <= 1'b0;
            abort_o <= 1'b0;
            shdn_q  <= 1'b1;
        end else begin
            shdn_q  <= shdn_n;
            abort_o <= !shdn_n && busy_o;
            if (!shdn_n) begin
                state_o <= PS_SLEEP;
                busy_o  <= 1'b0;
            end else if (wake_o) begin
                state_o <= PS_ACTIVE;
                busy_o  <= start_det;
            end else if (start_det) begin
                busy_o  <= 1'b1;
            end else if (conv_done && busy_o) begin
                busy_o  <= 1'b0;
                state_o <= pd_decode(pd_sel);
            end
        end
    end

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        shdn_n && start_det |=> busy_o && state_o == PS_ACTIVE) else $error("start"); // R5
    AST_DONE_DROPS_CMP: assert property (@(posedge clk) disable iff (rst)
        shdn_n && busy_o && conv_done && !start_det |=> !busy_o) else $error("done"); // R11
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        !shdn_n && busy_o |=> abort_o) else $error("abort"); // R10
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o) else $error("abort width"); // R10

endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rst_val,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          ready_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= rst_val;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign ready_o = (cnt == '0);

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        !load && cnt != '0 |=> cnt == $past(cnt) - 1'b1) else $error("count"); // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val)) else $error("load"); // R6

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int unsigned NAP_WAKE_CYC   = 20000,
    parameter int unsigned SLEEP_WAKE_CYC = 900000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shdn_n,
    input  logic       ext_ref,
    input  logic [1:0] pd_sel,
    input  logic       start_det,
    input  logic       conv_done,
    output logic       cmp_en,
    output logic       ref_en,
    output logic       ana_en,
    output logic       ref_ready,
    output logic       conv_abort
);

    localparam int unsigned MAX_WAKE = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ?
                                       SLEEP_WAKE_CYC : NAP_WAKE_CYC;
    localparam int CW = $clog2(MAX_WAKE + 1);

    pwr_state_t    state;
    pwr_state_t    wake_from;
    logic          busy;
    logic          wake;
    logic          tmr_ready;
    logic [CW-1:0] load_val;
    logic [CW-1:0] rst_val;

    adc_pwr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .shdn_n      (shdn_n),
        .start_det   (start_det),
        .conv_done   (conv_done),
        .pd_sel      (pd_sel),
        .state_o     (state),
        .busy_o      (busy),
        .abort_o     (conv_abort),
        .wake_o      (wake),
        .wake_from_o (wake_from)
    );

    assign load_val = CW'(wake_cycles(wake_from, ext_ref, NAP_WAKE_CYC, SLEEP_WAKE_CYC));
    assign rst_val  = CW'(wake_cycles(PS_SLEEP, ext_ref, NAP_WAKE_CYC, SLEEP_WAKE_CYC));

    adc_settle_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .rst_val  (rst_val),
        .load     (wake),
        .load_val (load_val),
        .ready_o  (tmr_ready)
    );

    assign ana_en    = (state == PS_ACTIVE);
    assign ref_en    = !ext_ref && (state != PS_SLEEP);
    assign cmp_en    = busy;
    assign ref_ready = (state == PS_ACTIVE) && tmr_ready;

    AST_SHDN_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> !ana_en && !ref_en && !cmp_en && !ref_ready) else $error("shdn"); // R8
    AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        ref_ready |-> ana_en) else $error("ready"); // R6
    AST_NAP_KEEPS_REF: assert property (@(posedge clk) disable iff (rst)
        shdn_n && cmp_en && conv_done && !start_det && pd_sel == 2'b01 && !ext_ref
        |=> ref_en && !ana_en) else $error("nap"); // R3
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
        shdn_n && cmp_en && conv_done && !start_det && pd_sel == 2'b00
        |=> !ref_en && !ana_en) else $error("sleep"); // R2
    AST_EXT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        shdn_n && ext_ref && start_det && !ana_en |=> ref_ready) else $error("ext"); // R7

endmodule

// File: tb/adc_pwr_ctrl_bench.sv
module adc_pwr_ctrl_bench;

    localparam int NAP_N   = 40;
    localparam int SLEEP_N = 120;

    logic       clk = 1'b0;
    logic       rst, shdn_n, ext_ref, start_det, conv_done;
    logic [1:0] pd_sel;
    logic       cmp_en, ref_en, ana_en, ref_ready, conv_abort;

    int checks = 0;
    int errors = 0;
    int mstate = 0; // bench model: 0 powered, 1 nap, 2 sleep

    always #5 clk = ~clk;

    adc_pwr_ctrl #(.NAP_WAKE_CYC(NAP_N), .SLEEP_WAKE_CYC(SLEEP_N)) u_adc_pwr_ctrl (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .ext_ref(ext_ref), .pd_sel(pd_sel),
        .start_det(start_det), .conv_done(conv_done), .cmp_en(cmp_en), .ref_en(ref_en),
        .ana_en(ana_en), .ref_ready(ref_ready), .conv_abort(conv_abort)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_state(input logic [1:0] pd);
        return (pd == 2'b00) ? 2 : (pd == 2'b01) ? 1 : 0;
    endfunction

    function automatic int exp_wake(input int st, input logic ext);
        if (st == 0) return -1;
        if (ext) return 0;
        return (st == 1) ? NAP_N : SLEEP_N;
    endfunction

    // Called at the sample point right after the wake edge
    task automatic ready_window(input string req, input int n);
        for (int j = 0; j < n; j++) begin
            if (j == 0 || j == n - 1) chk(req, "ref_ready low", ref_ready, 1'b0);
            @(negedge clk);
        end
        chk(req, "ref_ready high", ref_ready, 1'b1);
    endtask

    task automatic run_conv(input logic [1:0] pd, input int hold);
        int w;
        w = exp_wake(mstate, ext_ref);
        pd_sel    = pd;
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        chk("R5", "ana_en after start", ana_en, 1'b1);
        chk("R11", "cmp_en after start", cmp_en, 1'b1);
        if (w >= 0) ready_window(ext_ref ? "R7" : "R6", w);
        else chk("R6", "ref_ready stays", ref_ready, 1'b1);
        repeat (hold) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        mstate = exp_state(pd);
        chk("R11", "cmp_en after done", cmp_en, 1'b0);
        chk(pd == 2'b00 ? "R2" : pd == 2'b01 ? "R3" : "R4", "ana_en", ana_en, pd[1]);
        chk(ext_ref ? "R7" : (pd == 2'b01 ? "R3" : "R2"), "ref_en", ref_en,
            !ext_ref && pd != 2'b00);
        chk("R4", "ref_ready after done", ref_ready, pd[1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; shdn_n = 1'b1; ext_ref = 1'b0; pd_sel = 2'b00;
        start_det = 1'b0; conv_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "ana_en", ana_en, 1'b1);
        chk("R1", "ref_en", ref_en, 1'b1);
        chk("R1", "cmp_en", cmp_en, 1'b0);
        chk("R1", "conv_abort", conv_abort, 1'b0);
        ready_window("R1", SLEEP_N);

        run_conv(2'b10, 3);              // R4 stay powered
        run_conv(2'b01, 2);              // R3 nap
        repeat (5) @(negedge clk);
        chk("R3", "ref_en held in nap", ref_en, 1'b1);
        run_conv(2'b00, 4);              // R6 nap wake, R2 sleep
        run_conv(2'b11, 2);              // R6 sleep wake, R4

        ext_ref = 1'b1;                  // R7
        @(negedge clk);
        chk("R7", "ref_en with external", ref_en, 1'b0);
        run_conv(2'b00, 2);
        run_conv(2'b01, 2);
        run_conv(2'b10, 2);
        ext_ref = 1'b0;
        @(negedge clk);

        shdn_n = 1'b0;                   // R8
        @(negedge clk);
        chk("R8", "ana_en", ana_en, 1'b0);
        chk("R8", "ref_en", ref_en, 1'b0);
        chk("R8", "ref_ready", ref_ready, 1'b0);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        chk("R8", "cmp_en ignores start", cmp_en, 1'b0);
        chk("R8", "ana_en ignores start", ana_en, 1'b0);
        shdn_n = 1'b1;                   // R9
        @(negedge clk);
        chk("R9", "ana_en", ana_en, 1'b1);
        chk("R9", "ref_en", ref_en, 1'b1);
        ready_window("R9", SLEEP_N);
        mstate = 0;

        pd_sel = 2'b00; start_det = 1'b1; // R10
        @(negedge clk);
        start_det = 1'b0;
        shdn_n = 1'b0;
        @(negedge clk);
        chk("R10", "conv_abort pulse", conv_abort, 1'b1);
        chk("R10", "cmp_en off", cmp_en, 1'b0);
        @(negedge clk);
        chk("R10", "conv_abort single", conv_abort, 1'b0);
        shdn_n = 1'b1;
        @(negedge clk);
        ready_window("R9", SLEEP_N);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R10", "stale done ignored", ana_en, 1'b1);
        chk("R10", "ready kept", ref_ready, 1'b1);
        mstate = 0;

        for (int i = 0; i < 25; i++) begin
            logic [1:0] p;
            int h;
            p = 2'($urandom_range(0, 3));
            h = int'($urandom_range(1, 8));
            run_conv(p, h);
            repeat (int'($urandom_range(0, 4))) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule